// File: doc/BRIEF.md
# Triggered Waveform Playback Controller

This block plays one stored waveform from a sample memory out to a data port. The memory is a plain synchronous read port. Each memory word holds two samples, with the even-indexed sample in the lower half. In single-rate mode the block emits one sample per clock. In double-rate mode it emits a whole word, which is two samples, per clock. The waveform can be played once, a programmed number of times, or continuously until it is stopped.

Playback is governed by three trigger inputs: start, pause and stop. Each trigger passes through a two-flop synchronizer before its edge or level is detected. Start and stop are edge-detected, and either edge can be selected. Pause is level-detected with selectable polarity, and it takes effect between samples. A data-active flag marks each cycle that carries a fresh sample. Three marker outputs pulse on programmed sample indices. A done flag reports that playback has ended and that the output pipeline has drained.

Software configures the block through a small write-only register port. Writing the control register with the arm bit set checks the whole configuration. If the configuration is consistent, the block enters the ready state. If not, the error flag is raised and the block stays stopped.

Top module: `wave_play_ctrl`

## Requirements
- R1: After a synchronous active-low reset, data_active, done, ready, cfg_err, markers and mem_rd_en are all low.
- R2: The configuration registers are: address 0 control, 1 length in samples, 2 repeat count, 3 to 5 marker indices 0 to 2. The control register bits are: bit 0 arm, bit 1 double-rate, bits 3:2 repeat mode (0 once, 1 counted, 2 continuous), bit 4 start enable, bit 5 start on falling edge, bit 6 pause enable, bit 7 pause active low, bit 8 stop enable, bit 9 stop on falling edge. A valid arm write makes ready high until playback starts.
- R3: With start enabled, playback begins only on the selected edge of start_trig. Neither the other edge nor a steady level starts it. With start disabled, playback begins immediately after arming.
- R4: In once mode, samples 0 to length-1 are output in index order exactly once, and then done goes high.
- R5: data_active is high on exactly those cycles that present a new sample, and it is never high while done is high.
- R6: In counted mode the waveform is played repeat-count times back to back. Counts up to 16,777,216 are accepted.
- R7: In continuous mode the waveform repeats until the selected stop edge arrives. After that edge, done goes high and no further samples appear. The non-selected stop edge has no effect.
- R8: While the pause level is active, data_active is low and sample_out holds its last value. When the pause level clears, playback resumes with the next sample, with none skipped and none repeated. Either polarity is selectable.
- R9: In double-rate mode each output cycle carries the sample pair {index 2k+1, index 2k} in the upper and lower halves. In single-rate mode the sample sits in the lower half and the upper half is zero.
- R10: Marker output k is high on exactly the output cycle that carries sample index marker k. In double-rate mode this is the cycle whose pair starts at that index.
- R11: An arm write is rejected, with cfg_err set and ready low, if any of these holds: the length is 0; the length exceeds twice the memory depth; double-rate mode has an odd length; double-rate mode has an odd marker index; counted mode has a repeat count of 0 or above 16,777,216; the repeat mode is 3. A valid arm write clears cfg_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| start_trig | input | 1 | Asynchronous start trigger |
| pause_trig | input | 1 | Asynchronous pause trigger level |
| stop_trig | input | 1 | Asynchronous stop trigger |
| mem_rd_en | output | 1 | Sample memory read enable |
| mem_addr | output | ADDR_W | Sample memory word address |
| mem_rdata | input | 2*SMP_W | Memory word, valid one cycle after the read |
| sample_out | output | 2*SMP_W | Output sample or sample pair |
| data_active | output | 1 | Fresh sample on sample_out this cycle |
| markers | output | 3 | Marker pulses |
| done | output | 1 | Playback ended and pipeline drained |
| ready | output | 1 | Armed and waiting for start |
| cfg_err | output | 1 | Last arm attempt was rejected |

## Verification
The playback path is driven with several patterns: single-rate once, counted repeats, continuous play interrupted by pauses of both polarities, and double-rate pairs. The stream that comes out is compared against an index-derived sample value. A skipped, repeated or wrongly laned sample then shows up as a value mismatch, and a wrong pass count shows up as a length mismatch. Start and stop are each driven with the edge that should be ignored before the edge that should act, which separates edge selection from plain edge detection. A set of deliberately broken configurations is also armed, one at a time, so that each validation rule is tested on its own.

// File: rtl/wpc_pkg.sv
// Shared types for the waveform playback controller.
// Assumes the control register layout described in the brief (bits 9:1).
package wpc_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_WAIT = 2'd1,
        S_PLAY = 2'd2,
        S_DONE = 2'd3
    } seq_state_t;

    localparam logic [1:0] REP_ONCE  = 2'd0;
    localparam logic [1:0] REP_COUNT = 2'd1;
    localparam logic [1:0] REP_CONT  = 2'd2;

    localparam int ADDR_CTRL  = 0;
    localparam int ADDR_LEN   = 1;
    localparam int ADDR_REPS  = 2;
    localparam int MARK_BASE  = 3;

    typedef struct packed {
        logic       stop_fall;
        logic       stop_en;
        logic       pause_low;
        logic       pause_en;
        logic       start_fall;
        logic       start_en;
        logic [1:0] mode;
        logic       ddr;
    } ctrl_t;

endpackage

// File: rtl/wpc_trig.sv
// Trigger front end: multi-flop synchronizer, then edge or level detection.
// EDGE=1 gives a one-cycle pulse on the selected edge (inv=1 selects falling).
// EDGE=0 gives a level that is active high, or active low when inv=1.
// Assumes din is asynchronous and wider than a couple of clock periods.
module wpc_trig #(
    parameter int STAGES = 2,
    parameter bit EDGE   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic en,
    input  logic inv,
    output logic hit
);

    generate
        if (EDGE) begin : g_edge
            logic [STAGES:0] sh;

            // Synchronize, keeping one extra stage for edge compare
            always_ff @(posedge clk) begin
                if (!rst_n) sh <= '0;
                else        sh <= {sh[STAGES-1:0], din};
            end

            assign hit = en & (inv ? (~sh[STAGES-1] & sh[STAGES])
                                   : (sh[STAGES-1] & ~sh[STAGES]));
        end else begin : g_level
            logic [STAGES-1:0] sh;

            // Synchronize the level
            always_ff @(posedge clk) begin
                if (!rst_n) sh <= '0;
                else        sh <= {sh[STAGES-2:0], din};
            end

            assign hit = en & (sh[STAGES-1] ^ inv);
        end
    endgenerate

endmodule

// File: rtl/wpc_cfg.sv
// Configuration registers and arm-time validation.
// Writes are taken only while cfg_open (idle, or done with pipeline drained).
// Writing the control register with bit 0 set is an arm request. It is
// checked against the new control value and the stored length, count and markers.
module wpc_cfg
    import wpc_pkg::*;
#(
    parameter int CFG_W    = 32,
    parameter int CA_W     = 3,
    parameter int NMARK    = 3,
    parameter int LEN_W    = 8,
    parameter int REP_W    = 25,
    parameter int MAX_LEN  = 128,
    parameter int MAX_REPS = 16777216
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [CA_W-1:0]             cfg_addr,
    input  logic [CFG_W-1:0]            cfg_wdata,
    input  logic                        cfg_open,
    output ctrl_t                       ctrl,
    output logic [LEN_W-1:0]            len,
    output logic [REP_W-1:0]            reps,
    output logic [NMARK-1:0][CFG_W-1:0] marks,
    output logic                        arm_go,
    output logic                        cfg_err
);

    localparam int CB = $bits(ctrl_t);

    ctrl_t                       ctrl_q;
    logic [CFG_W-1:0]            len_q;
    logic [CFG_W-1:0]            reps_q;
    logic [NMARK-1:0][CFG_W-1:0] mark_q;
    logic                        err_q;

    ctrl_t nc;
    logic  wr, arm_req, mark_odd, bad;

    // Decode the write and evaluate every rejection rule
    always_comb begin
        wr       = cfg_we & cfg_open;
        nc       = ctrl_t'(cfg_wdata[CB:1]);
        arm_req  = wr && (cfg_addr == CA_W'(ADDR_CTRL)) && cfg_wdata[0];
        mark_odd = 1'b0;
        for (int k = 0; k < NMARK; k++) mark_odd = mark_odd | mark_q[k][0];
        bad = (len_q == '0)
            || (len_q > CFG_W'(MAX_LEN))
            || (nc.ddr && len_q[0])
            || (nc.ddr && mark_odd)
            || (nc.mode == 2'd3)
            || ((nc.mode == REP_COUNT) && ((reps_q == '0) || (reps_q > CFG_W'(MAX_REPS))));
        arm_go = arm_req & ~bad;
    end

    // Register writes and the error flag of the last arm attempt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            len_q  <= '0;
            reps_q <= '0;
            mark_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (wr) begin
                if (cfg_addr == CA_W'(ADDR_CTRL)) ctrl_q <= nc;
                if (cfg_addr == CA_W'(ADDR_LEN))  len_q  <= cfg_wdata;
                if (cfg_addr == CA_W'(ADDR_REPS)) reps_q <= cfg_wdata;
                for (int k = 0; k < NMARK; k++)
                    if (cfg_addr == CA_W'(MARK_BASE + k)) mark_q[k] <= cfg_wdata;
            end
            if (arm_req) err_q <= bad;
        end
    end

    assign ctrl    = ctrl_q;
    assign len     = len_q[LEN_W-1:0];
    assign reps    = reps_q[REP_W-1:0];
    assign marks   = mark_q;
    assign cfg_err = err_q;

endmodule

// File: rtl/wpc_seq.sv
// Playback sequencer: arm/start/play/done state machine, sample index and
// pass counter. A sample is issued in every play cycle that has neither
// pause nor stop. The index steps by 1 (single rate) or 2 (double rate).
// Assumes the configuration was validated at arm time and is stable while playing.
module wpc_seq
    import wpc_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter int REP_W = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ddr,
    input  logic [1:0]       mode,
    input  logic [LEN_W-1:0] len,
    input  logic [REP_W-1:0] reps,
    input  logic             arm_go,
    input  logic             start_hit,
    input  logic             pause_act,
    input  logic             stop_hit,
    input  logic             drained,
    output logic             iss_v,
    output logic [LEN_W-1:0] iss_idx,
    output logic             ready,
    output logic             done,
    output logic             cfg_open
);

    seq_state_t       st;
    logic [LEN_W-1:0] idx;
    logic [REP_W-1:0] pass_cnt;
    logic [LEN_W:0]   nxt;
    logic             wrap, finish;

    // Next index, end-of-pass and end-of-playback detection
    always_comb begin
        nxt    = {1'b0, idx} + (ddr ? (LEN_W+1)'(2) : (LEN_W+1)'(1));
        wrap   = (nxt == {1'b0, len});
        finish = wrap && ((mode == REP_ONCE) ||
                          ((mode == REP_COUNT) && ((pass_cnt + 1'b1) == reps)));
    end

    // State, index and pass counter update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            idx      <= '0;
            pass_cnt <= '0;
        end else begin
            unique case (st)
                S_IDLE, S_DONE: if (arm_go) st <= S_WAIT;
                S_WAIT: if (start_hit) begin
                    st       <= S_PLAY;
                    idx      <= '0;
                    pass_cnt <= '0;
                end
                S_PLAY: begin
                    if (stop_hit) begin
                        st <= S_DONE;
                    end else if (!pause_act) begin
                        if (finish) st <= S_DONE;
                        if (wrap) begin
                            idx      <= '0;
                            pass_cnt <= pass_cnt + 1'b1;
                        end else begin
                            idx <= nxt[LEN_W-1:0];
                        end
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign iss_v    = (st == S_PLAY) && !stop_hit && !pause_act;
    assign iss_idx  = idx;
    assign ready    = (st == S_WAIT);
    assign done     = (st == S_DONE) && drained;
    assign cfg_open = (st == S_IDLE) || done;

endmodule

// File: rtl/wpc_out.sv
// Output stage: one tag register that lines up with the memory read latency,
// then the registered sample, data-active and marker outputs.
// Assumes mem_rdata is valid exactly one cycle after the read is issued.
module wpc_out #(
    parameter int SMP_W = 8,
    parameter int LEN_W = 8,
    parameter int CFG_W = 32,
    parameter int NMARK = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        iss_v,
    input  logic [LEN_W-1:0]            iss_idx,
    input  logic                        ddr,
    input  logic [NMARK-1:0][CFG_W-1:0] marks,
    input  logic [2*SMP_W-1:0]          mem_rdata,
    output logic [2*SMP_W-1:0]          sample_out,
    output logic                        data_active,
    output logic [NMARK-1:0]            markers,
    output logic                        drained
);

    logic [NMARK-1:0] hit, p1_mk, mk_q;
    logic             p1_v, p1_lane, p1_ddr, o_v;
    logic [2*SMP_W-1:0] smp_q;

    // One index comparator per marker
    generate
        for (genvar k = 0; k < NMARK; k++) begin : g_hit
            assign hit[k] = (CFG_W'(iss_idx) == marks[k]);
        end
    endgenerate

    // Tag stage aligned with the read latency, then the output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p1_v    <= 1'b0;
            p1_lane <= 1'b0;
            p1_ddr  <= 1'b0;
            p1_mk   <= '0;
            o_v     <= 1'b0;
            mk_q    <= '0;
            smp_q   <= '0;
        end else begin
            p1_v    <= iss_v;
            p1_lane <= iss_idx[0];
            p1_ddr  <= ddr;
            p1_mk   <= iss_v ? hit : '0;
            o_v     <= p1_v;
            mk_q    <= p1_v ? p1_mk : '0;
            if (p1_v)
                smp_q <= p1_ddr ? mem_rdata
                       : {{SMP_W{1'b0}}, (p1_lane ? mem_rdata[2*SMP_W-1:SMP_W]
                                                  : mem_rdata[SMP_W-1:0])};
        end
    end

    assign sample_out  = smp_q;
    assign data_active = o_v;
    assign markers     = mk_q;
    assign drained     = ~p1_v & ~o_v;

endmodule

// File: rtl/wave_play_ctrl.sv
// Top of the triggered waveform playback controller.
// Connects the trigger front ends, configuration, sequencer and output stage.
// Assumes a sample memory with one-cycle read latency and two samples per word.
module wave_play_ctrl
    import wpc_pkg::*;
#(
    parameter int SMP_W       = 8,
    parameter int ADDR_W      = 6,
    parameter int NMARK       = 3,
    parameter int SYNC_STAGES = 2,
    localparam int CFG_W    = 32,
    localparam int CA_W     = $clog2(MARK_BASE + NMARK),
    localparam int LEN_W    = ADDR_W + 2,
    localparam int MAX_LEN  = 2 ** (ADDR_W + 1),
    localparam int MAX_REPS = 2 ** 24,
    localparam int REP_W    = $clog2(MAX_REPS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [CA_W-1:0]     cfg_addr,
    input  logic [CFG_W-1:0]    cfg_wdata,
    input  logic                start_trig,
    input  logic                pause_trig,
    input  logic                stop_trig,
    output logic                mem_rd_en,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic [2*SMP_W-1:0]  mem_rdata,
    output logic [2*SMP_W-1:0]  sample_out,
    output logic                data_active,
    output logic [NMARK-1:0]    markers,
    output logic                done,
    output logic                ready,
    output logic                cfg_err
);

    ctrl_t                       ctrl;
    logic [LEN_W-1:0]            len;
    logic [REP_W-1:0]            reps;
    logic [NMARK-1:0][CFG_W-1:0] marks;
    logic                        arm_go, cfg_open, drained;
    logic                        iss_v;
    logic [LEN_W-1:0]            iss_idx;
    logic [2:0]                  t_raw, t_en, t_inv, t_hit;
    logic                        start_hit;

    // Trigger order: 0 start (edge), 1 pause (level), 2 stop (edge)
    assign t_raw = {stop_trig, pause_trig, start_trig};
    assign t_en  = {ctrl.stop_en, ctrl.pause_en, ctrl.start_en};
    assign t_inv = {ctrl.stop_fall, ctrl.pause_low, ctrl.start_fall};

    generate
        for (genvar g = 0; g < 3; g++) begin : g_trig
            wpc_trig #(.STAGES(SYNC_STAGES), .EDGE(g != 1)) u_trig (
                .clk   (clk),
                .rst_n (rst_n),
                .din   (t_raw[g]),
                .en    (t_en[g]),
                .inv   (t_inv[g]),
                .hit   (t_hit[g])
            );
        end
    endgenerate

    assign start_hit = ~ctrl.start_en | t_hit[0];

    wpc_cfg #(
        .CFG_W(CFG_W), .CA_W(CA_W), .NMARK(NMARK), .LEN_W(LEN_W),
        .REP_W(REP_W), .MAX_LEN(MAX_LEN), .MAX_REPS(MAX_REPS)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_open(cfg_open), .ctrl(ctrl), .len(len),
        .reps(reps), .marks(marks), .arm_go(arm_go), .cfg_err(cfg_err)
    );

    wpc_seq #(.LEN_W(LEN_W), .REP_W(REP_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .ddr(ctrl.ddr), .mode(ctrl.mode), .len(len),
        .reps(reps), .arm_go(arm_go), .start_hit(start_hit), .pause_act(t_hit[1]),
        .stop_hit(t_hit[2]), .drained(drained), .iss_v(iss_v), .iss_idx(iss_idx),
        .ready(ready), .done(done), .cfg_open(cfg_open)
    );

    wpc_out #(.SMP_W(SMP_W), .LEN_W(LEN_W), .CFG_W(CFG_W), .NMARK(NMARK)) u_out (
        .clk(clk), .rst_n(rst_n), .iss_v(iss_v), .iss_idx(iss_idx), .ddr(ctrl.ddr),
        .marks(marks), .mem_rdata(mem_rdata), .sample_out(sample_out),
        .data_active(data_active), .markers(markers), .drained(drained)
    );

    assign mem_rd_en = iss_v;
    assign mem_addr  = iss_idx[ADDR_W:1];

endmodule

// File: rtl/wpc_chk.sv
// Protocol checker for wave_play_ctrl, attached through bind.
// Assumes only the top-level ports of the controller.
module wpc_chk #(
    parameter int NMARK = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mem_rd_en,
    input logic             data_active,
    input logic [NMARK-1:0] markers,
    input logic             done,
    input logic             ready,
    input logic             cfg_err
);

    // R5
    active_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_active |-> !done);

    // R5
    active_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_active |-> $past(mem_rd_en, 2));

    // R10
    marker_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|markers) |-> data_active);

    // R11
    err_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !ready);

    // R4
    done_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_rd_en);

    // R2
    ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (!data_active && !mem_rd_en));

endmodule

bind wave_play_ctrl wpc_chk #(.NMARK(NMARK)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_rd_en(mem_rd_en), .data_active(data_active),
    .markers(markers), .done(done), .ready(ready), .cfg_err(cfg_err)
);

// File: tb/tb_wave_play_ctrl.sv
// Directed bench for wave_play_ctrl: one task per scenario.
module tb_wave_play_ctrl;

    localparam int SMP_W  = 8;
    localparam int ADDR_W = 6;
    localparam logic [1:0] M_ONCE = 2'd0, M_CNT = 2'd1, M_CONT = 2'd2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        start_trig = 1'b0, pause_trig = 1'b0, stop_trig = 1'b0;
    logic        mem_rd_en;
    logic [ADDR_W-1:0] mem_addr;
    logic [15:0] mem_rdata = '0;
    logic [15:0] sample_out;
    logic        data_active, done, ready, cfg_err;
    logic [2:0]  markers;

    int checks = 0, fails = 0, ngot = 0;
    bit finished = 1'b0;
    logic [15:0] got [0:1023];
    logic [2:0]  mkl [0:1023];

    wave_play_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .start_trig(start_trig), .pause_trig(pause_trig),
        .stop_trig(stop_trig), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .sample_out(sample_out), .data_active(data_active),
        .markers(markers), .done(done), .ready(ready), .cfg_err(cfg_err)
    );

    always #5 clk = ~clk;

    function automatic logic [7:0] smp(int i);
        return 8'(i * 7 + 3);
    endfunction

    // Sample memory model, one-cycle read latency
    always @(posedge clk)
        if (mem_rd_en) mem_rdata <= {smp(2 * int'(mem_addr) + 1), smp(2 * int'(mem_addr))};

    // Output stream recorder
    always @(negedge clk)
        if (rst_n && data_active && ngot < 1024) begin
            got[ngot] = sample_out;
            mkl[ngot] = markers;
            ngot++;
        end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [31:0] ctl(bit ddr, logic [1:0] m, bit sen, bit sf,
                                        bit pen, bit pl, bit ten, bit tf);
        return {22'd0, tf, ten, pl, pen, sf, sen, m, ddr, 1'b1};
    endfunction

    task automatic wait_done(int lim);
        for (int i = 0; i < lim && !done; i++) @(negedge clk);
    endtask

    task automatic wait_cnt(int n, int lim);
        for (int i = 0; i < lim && ngot < n; i++) @(negedge clk);
    endtask

    task automatic quiet();
        start_trig = 1'b0; pause_trig = 1'b0; stop_trig = 1'b0;
        repeat (4) @(negedge clk);
        ngot = 0;
    endtask

    function automatic int seq_errs(int period);
        int e = 0;
        for (int i = 0; i < ngot; i++)
            if (got[i] !== {8'h00, smp(i % period)}) e++;
        return e;
    endfunction

    task automatic t_reset();
        chk("R1 data_active", data_active, 0);
        chk("R1 done", done, 0);
        chk("R1 ready", ready, 0);
        chk("R1 cfg_err", cfg_err, 0);
        chk("R1 markers", markers, 0);
        chk("R1 mem_rd_en", mem_rd_en, 0);
    endtask

    task automatic t_once_markers();
        quiet();
        wr(1, 12); wr(3, 3); wr(4, 7); wr(5, 11);
        wr(0, ctl(0, M_ONCE, 0, 0, 0, 0, 0, 0));
        wait_done(200);
        chk("R4 count", ngot, 12);
        chk("R4 order", seq_errs(12), 0);
        chk("R4 done", done, 1);
        chk("R5 idle after done", data_active, 0);
        chk("R10 mark0", mkl[3], 3'b001);
        chk("R10 mark1", mkl[7], 3'b010);
        chk("R10 mark2", mkl[11], 3'b100);
        chk("R10 mark quiet", mkl[0] | mkl[5] | mkl[10], 0);
    endtask

    task automatic t_count_rise();
        quiet();
        wr(1, 5); wr(2, 3);
        wr(0, ctl(0, M_CNT, 1, 0, 0, 0, 0, 0));
        repeat (20) @(negedge clk);
        chk("R2 ready", ready, 1);
        chk("R3 no start without edge", ngot, 0);
        start_trig = 1'b1; repeat (3) @(negedge clk); start_trig = 1'b0;
        wait_done(300);
        chk("R6 three passes", ngot, 15);
        chk("R6 order", seq_errs(5), 0);
        chk("R6 done", done, 1);
    endtask

    task automatic t_start_fall();
        quiet();
        wr(1, 4);
        wr(0, ctl(0, M_ONCE, 1, 1, 0, 0, 0, 0));
        start_trig = 1'b1;
        repeat (10) @(negedge clk);
        chk("R3 rising ignored", ngot, 0);
        chk("R3 still ready", ready, 1);
        start_trig = 1'b0;
        wait_done(100);
        chk("R3 falling starts", ngot, 4);
        chk("R3 order", seq_errs(4), 0);
    endtask

    task automatic arm_bad(string req, logic [31:0] c);
        wr(0, c);
        chk({req, " err"}, cfg_err, 1);
        chk({req, " not ready"}, ready, 0);
    endtask

    task automatic t_errors();
        quiet();
        wr(1, 0);   arm_bad("R11 zero length", ctl(0, M_ONCE, 0, 0, 0, 0, 0, 0));
        wr(1, 129); arm_bad("R11 long length", ctl(0, M_ONCE, 0, 0, 0, 0, 0, 0));
        wr(1, 7);   arm_bad("R11 odd ddr length", ctl(1, M_ONCE, 0, 0, 0, 0, 0, 0));
        wr(1, 8); wr(3, 2); wr(4, 5); wr(5, 6);
        arm_bad("R11 odd ddr marker", ctl(1, M_ONCE, 0, 0, 0, 0, 0, 0));
        wr(1, 4); wr(2, 0);
        arm_bad("R11 zero count", ctl(0, M_CNT, 0, 0, 0, 0, 0, 0));
        wr(2, 32'd16777217);
        arm_bad("R11 count too big", ctl(0, M_CNT, 0, 0, 0, 0, 0, 0));
        arm_bad("R11 mode three", ctl(0, 2'd3, 0, 0, 0, 0, 0, 0));
        chk("R11 no output", ngot, 0);
    endtask

    task automatic t_ddr();
        quiet();
        wr(1, 8); wr(3, 2); wr(4, 4); wr(5, 6);
        wr(0, ctl(1, M_ONCE, 0, 0, 0, 0, 0, 0));
        chk("R11 valid arm clears err", cfg_err, 0);
        wait_done(100);
        chk("R9 words", ngot, 4);
        for (int k = 0; k < 4; k++)
            chk("R9 pair", got[k], {smp(2 * k + 1), smp(2 * k)});
        chk("R10 ddr m none", mkl[0], 3'b000);
        chk("R10 ddr m0", mkl[1], 3'b001);
        chk("R10 ddr m1", mkl[2], 3'b010);
        chk("R10 ddr m2", mkl[3], 3'b100);
    endtask

    task automatic t_pause_high();
        int n1, n2;
        logic [15:0] held;
        quiet();
        wr(1, 6); wr(3, 200); wr(4, 200); wr(5, 200);
        wr(0, ctl(0, M_CONT, 0, 0, 1, 0, 1, 0));
        wait_cnt(4, 100);
        pause_trig = 1'b1;
        repeat (8) @(negedge clk);
        chk("R8 paused inactive", data_active, 0);
        n1 = ngot; held = sample_out;
        repeat (6) @(negedge clk);
        chk("R8 no samples in pause", ngot, n1);
        chk("R8 output held", sample_out, held);
        chk("R8 held is last", held, got[n1-1]);
        pause_trig = 1'b0;
        wait_cnt(n1 + 10, 100);
        stop_trig = 1'b1;
        wait_done(60);
        chk("R7 stop done", done, 1);
        n2 = ngot;
        repeat (10) @(negedge clk);
        chk("R7 no samples after stop", ngot, n2);
        chk("R8 resume no skip", seq_errs(6), 0);
    endtask

    task automatic t_pause_low_stop_fall();
        int n1;
        quiet();
        pause_trig = 1'b1;
        repeat (4) @(negedge clk);
        wr(1, 6);
        wr(0, ctl(0, M_CONT, 0, 0, 1, 1, 1, 1));
        wait_cnt(3, 100);
        chk("R8 high level plays when active-low", ngot >= 3, 1);
        pause_trig = 1'b0;
        repeat (8) @(negedge clk);
        chk("R8 low level pauses", data_active, 0);
        n1 = ngot;
        repeat (5) @(negedge clk);
        chk("R8 low pause holds", ngot, n1);
        pause_trig = 1'b1;
        wait_cnt(n1 + 4, 100);
        stop_trig = 1'b1;
        repeat (8) @(negedge clk);
        chk("R7 rising stop ignored", done, 0);
        stop_trig = 1'b0;
        wait_done(60);
        chk("R7 falling stop", done, 1);
        chk("R8 low polarity continuity", seq_errs(6), 0);
    endtask

    task automatic t_big_count();
        quiet();
        wr(1, 4); wr(2, 32'd16777216);
        wr(0, ctl(0, M_CNT, 0, 0, 0, 0, 1, 0));
        chk("R6 max count accepted", cfg_err, 0);
        wait_cnt(40, 200);
        chk("R6 still playing", done, 0);
        chk("R6 passes continue", seq_errs(4), 0);
        stop_trig = 1'b1;
        wait_done(60);
        chk("R6 stopped", done, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL R7 watchdog actual=hung expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_once_markers();
        t_count_rise();
        t_start_fall();
        t_errors();
        t_ddr();
        t_pause_high();
        t_pause_low_stop_fall();
        t_big_count();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule